// File: doc/BRIEF.md
# BCD Real-Time Clock with Freeze

This block keeps calendar time in packed BCD: seconds, minutes, hours (24-hour), day of month, day of week, month, year within the century and century. An external one-cycle pulse, `sec_tick`, marks each second. When the run bit is set, that pulse steps a set of internal counters. The host never reads those counters directly. It reads a second layer of byte registers, and that layer is reloaded from the counters one cycle after every step.

The control register holds a freeze bit. While freeze is set, the host layer is left alone and the counters keep stepping, so the host can read a consistent snapshot. In the same state the host can overwrite time fields. If any time field was written during the freeze, clearing freeze loads the whole host layer into the counters. If nothing was written, clearing freeze leaves the counters untouched, and the host layer catches up at the next step.

The block also holds an alarm on second, minute, hour and day of month. A flag is raised when those four fields match the time just stepped to. Reading the flag clears it. An interrupt output follows the flag when the interrupt enable is set.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads cent=0x20, year=0x00, month=0x01, weekday=0x01, mday=0x01, hour=0x00, min=0x00, sec=0x00. Control reads 0x01 (run on, freeze off), and enables, flags and the alarm registers read 0x00. Unused address 0xF reads 0x00.
- R2: The address map is as follows. Time fields are at 0x0 sec, 0x1 min, 0x2 hour, 0x3 mday, 0x4 weekday, 0x5 month, 0x6 year, 0x7 century. Alarm fields are at 0x8 sec, 0x9 min, 0xA hour, 0xB mday. Enables are at 0xC (bit0 interrupt enable, bit1 wake enable; the other bits read 0). Flags are at 0xD (bit0 alarm). Control is at 0xE (bit0 run, bit3 freeze). Reads are combinational from `addr` while `rd_en` is high.
- R3: If `sec_tick` is high at a clock edge while run=1, freeze=0 and no commit is taking place, the counters step at that edge. The host layer shows the new time after the following edge.
- R4: A step rolls over in BCD as follows: sec 59→00 and min 59→00 each carry; hour 23→00 carries into the day; weekday 07→01. A month of 30 or 31 days, or February with 28 days (29 when the year within the century is divisible by 4), rolls over to day 01 of the next month. Month 12→01 carries into the year, and year 99→00 increments the century.
- R5: With run=0, `sec_tick` has no effect on the counters.
- R6: While freeze=1 the host layer holds its value and the counters keep stepping. Clearing freeze with no time writes made changes nothing until the next step, which then shows the true counter time.
- R7: A transfer already pending when freeze is set still completes. If a step occurs at an edge while freeze=0, the host layer is reloaded at the next edge, even if freeze was written to 1 at the step edge or at the reload edge.
- R8: Writes to time addresses 0x0–0x7 while freeze=0 are ignored, both by the host layer and by the counters.
- R9: If a time field was written during a freeze, a control write that clears freeze loads all eight host fields into the counters at that edge. A `sec_tick` in that same cycle is dropped.
- R10: At the edge after a step, the alarm flag is set if the alarm sec, min, hour and mday equal the new counter values. `irq` equals flag AND the interrupt enable. The flag is set whether or not the interrupt is enabled.
- R11: A read of 0xD returns the flag and clears it at that edge. If the flag is set in the same cycle, the read returns the old value and the flag ends set.
- R12: The alarm registers and enable bits read back what was written, with masked bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag on a flags read) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq | output | 1 | Alarm interrupt |

## Verification
Two pairs of events can land on one clock edge. In the first pair, the control write that clears freeze and commits host writes meets a `sec_tick`. The bench drives both in one cycle and expects the written seconds to survive unchanged, with the step after it counting on from them. In the second pair, a read of the flags register meets the edge where an alarm match sets the flag. The bench raises the read strobe in the cycle right after a matching tick. It expects the read to return 0 and a second read to return 1. A third overlap is the freeze write placed on the reload edge, which must not suppress that reload.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam int NUM_TIME   = 8;
  localparam int FIELD_W    = 8;
  localparam int TIME_W     = NUM_TIME * FIELD_W;

  localparam int REG_ALM_SEC  = 8;
  localparam int REG_ALM_MIN  = 9;
  localparam int REG_ALM_HOUR = 10;
  localparam int REG_ALM_MDAY = 11;
  localparam int REG_ENABLES  = 12;
  localparam int REG_FLAGS    = 13;
  localparam int REG_CTRL     = 14;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_FRZ_BIT = 3;

  localparam rtc_time_t RTC_RST_DEFAULT = '{
    cent: 8'h20, year: 8'h00, mon: 8'h01, wday: 8'h01,
    mday: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Leap test: 10 mod 4 is 2, so (2*tens + ones) mod 4 decides.
  function automatic logic [7:0] month_days(input logic [7:0] mon,
                                            input logic [7:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    case (mon)
      8'h02:                      return (s[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter rtc_time_t RST_TIME = RTC_RST_DEFAULT
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t time_q
);

  rtc_time_t time_n;

  always_comb begin
    time_n = time_q;
    if (load) begin
      time_n = load_val;
    end else if (step) begin
      if (time_q.sec != 8'h59) time_n.sec = bcd_inc(time_q.sec);
      else begin
        time_n.sec = 8'h00;
        if (time_q.min != 8'h59) time_n.min = bcd_inc(time_q.min);
        else begin
          time_n.min = 8'h00;
          if (time_q.hour != 8'h23) time_n.hour = bcd_inc(time_q.hour);
          else begin
            time_n.hour = 8'h00;
            time_n.wday = (time_q.wday == 8'h07) ? 8'h01 : bcd_inc(time_q.wday);
            if (time_q.mday != month_days(time_q.mon, time_q.year))
              time_n.mday = bcd_inc(time_q.mday);
            else begin
              time_n.mday = 8'h01;
              if (time_q.mon != 8'h12) time_n.mon = bcd_inc(time_q.mon);
              else begin
                time_n.mon = 8'h01;
                if (time_q.year != 8'h99) time_n.year = bcd_inc(time_q.year);
                else begin
                  time_n.year = 8'h00;
                  time_n.cent = (time_q.cent == 8'h99) ? 8'h00 : bcd_inc(time_q.cent);
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             time_q <= RST_TIME;
    else if (load || step)  time_q <= time_n;
  end

  assert_load_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (time_q == $past(load_val)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(time_q));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       check,
  input  rtc_time_t  cur,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic [7:0] alm_mday,
  input  logic       rd_clr,
  input  logic       irq_en,
  output logic       flag_q,
  output logic       irq
);

  logic hit;
  logic flag_n;

  always_comb begin
    hit = check && (cur.sec == alm_sec) && (cur.min == alm_min) &&
          (cur.hour == alm_hour) && (cur.mday == alm_mday);
    flag_n = flag_q;
    if (hit)         flag_n = 1'b1;
    else if (rd_clr) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_n;
  end

  assign irq = flag_q & irq_en;

  assert_flag_needs_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !check) |=> !flag_q);

  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !check) |=> !flag_q);

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int        ADDR_W   = 4,
  parameter rtc_time_t RST_TIME = RTC_RST_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq
);

  localparam logic [TIME_W-1:0] RST_FLAT = RST_TIME;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s0, rst_s1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_ni = rst_s1;

  // Control and alarm state
  logic       run_q, frz_q, dirty_q, aie_q, wke_q, step_q, xfer_q;
  logic       run_n, frz_n, dirty_n, aie_n, wke_n;
  logic [7:0] asec_q, amin_q, ahour_q, amday_q;
  logic [7:0] asec_n, amin_n, ahour_n, amday_n;

  logic ctrl_wr, commit, step, time_wr, rd_clr, flag_q;
  logic [TIME_W-1:0] vis_flat;
  rtc_time_t cur_time;

  always_comb begin
    ctrl_wr = wr_en && (addr == ADDR_W'(REG_CTRL));
    commit  = ctrl_wr && frz_q && !wdata[CTRL_FRZ_BIT] && dirty_q;
    step    = sec_tick && run_q && !commit;
    time_wr = wr_en && frz_q && (addr < ADDR_W'(NUM_TIME));
    rd_clr  = rd_en && (addr == ADDR_W'(REG_FLAGS));
  end

  always_comb begin
    run_n   = run_q;
    frz_n   = frz_q;
    aie_n   = aie_q;
    wke_n   = wke_q;
    asec_n  = asec_q;
    amin_n  = amin_q;
    ahour_n = ahour_q;
    amday_n = amday_q;
    dirty_n = dirty_q;
    if (time_wr) dirty_n = 1'b1;
    if (ctrl_wr) begin
      run_n = wdata[CTRL_RUN_BIT];
      frz_n = wdata[CTRL_FRZ_BIT];
      if (!wdata[CTRL_FRZ_BIT]) dirty_n = 1'b0;
    end
    if (wr_en) begin
      if (addr == ADDR_W'(REG_ALM_SEC))  asec_n  = wdata;
      if (addr == ADDR_W'(REG_ALM_MIN))  amin_n  = wdata;
      if (addr == ADDR_W'(REG_ALM_HOUR)) ahour_n = wdata;
      if (addr == ADDR_W'(REG_ALM_MDAY)) amday_n = wdata;
      if (addr == ADDR_W'(REG_ENABLES)) begin
        aie_n = wdata[0];
        wke_n = wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b1;
      frz_q   <= 1'b0;
      dirty_q <= 1'b0;
      aie_q   <= 1'b0;
      wke_q   <= 1'b0;
      asec_q  <= 8'h00;
      amin_q  <= 8'h00;
      ahour_q <= 8'h00;
      amday_q <= 8'h00;
      step_q  <= 1'b0;
      xfer_q  <= 1'b0;
    end else begin
      run_q   <= run_n;
      frz_q   <= frz_n;
      dirty_q <= dirty_n;
      aie_q   <= aie_n;
      wke_q   <= wke_n;
      asec_q  <= asec_n;
      amin_q  <= amin_n;
      ahour_q <= ahour_n;
      amday_q <= amday_n;
      step_q  <= step;
      xfer_q  <= step && !frz_q;
    end
  end

  // Host-visible layer: a host write wins over a pending reload.
  logic [TIME_W-1:0] cur_flat;
  assign cur_flat = cur_time;

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_vis
    logic [7:0] fld_q, fld_n;
    always_comb begin
      fld_n = fld_q;
      if (time_wr && (addr == ADDR_W'(i))) fld_n = wdata;
      else if (xfer_q)                     fld_n = cur_flat[FIELD_W*i +: FIELD_W];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) fld_q <= RST_FLAT[FIELD_W*i +: FIELD_W];
      else         fld_q <= fld_n;
    end
    assign vis_flat[FIELD_W*i +: FIELD_W] = fld_q;
  end

  rtc_time_core #(.RST_TIME(RST_TIME)) u_core (
    .clk      (clk),
    .rst_n    (rst_ni),
    .step     (step),
    .load     (commit),
    .load_val (rtc_time_t'(vis_flat)),
    .time_q   (cur_time)
  );

  rtc_alarm u_alarm (
    .clk      (clk),
    .rst_n    (rst_ni),
    .check    (step_q),
    .cur      (cur_time),
    .alm_sec  (asec_q),
    .alm_min  (amin_q),
    .alm_hour (ahour_q),
    .alm_mday (amday_q),
    .rd_clr   (rd_clr),
    .irq_en   (aie_q),
    .flag_q   (flag_q),
    .irq      (irq)
  );

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NUM_TIME; i++)
      if (addr == ADDR_W'(i)) rdata = vis_flat[FIELD_W*i +: FIELD_W];
    if (addr == ADDR_W'(REG_ALM_SEC))  rdata = asec_q;
    if (addr == ADDR_W'(REG_ALM_MIN))  rdata = amin_q;
    if (addr == ADDR_W'(REG_ALM_HOUR)) rdata = ahour_q;
    if (addr == ADDR_W'(REG_ALM_MDAY)) rdata = amday_q;
    if (addr == ADDR_W'(REG_ENABLES))  rdata = {6'b0, wke_q, aie_q};
    if (addr == ADDR_W'(REG_FLAGS))    rdata = {7'b0, flag_q};
    if (addr == ADDR_W'(REG_CTRL))     rdata = {4'b0, frz_q, 2'b0, run_q};
  end

  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (frz_q && !xfer_q && !time_wr) |=> $stable(vis_flat));

  assert_ignore_write_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !frz_q && (addr < ADDR_W'(NUM_TIME)) && !xfer_q) |=> $stable(vis_flat));

  assert_run_gate_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_q && !commit) |=> $stable(cur_time));

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (xfer_q && !time_wr) |=> (vis_flat == $past(cur_flat)));

endmodule

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bcd_rtc uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #2 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    @(negedge clk);
  endtask

  // Fields: cent year mon wday mday hour min sec
  task automatic set_time(input logic [7:0] c, y, mo, wd, md, h, mi, s);
    wr(4'hE, 8'h09);
    wr(4'h0, s);  wr(4'h1, mi); wr(4'h2, h);  wr(4'h3, md);
    wr(4'h4, wd); wr(4'h5, mo); wr(4'h6, y);  wr(4'h7, c);
    wr(4'hE, 8'h01);
  endtask

  task automatic expect_time(input string req, input logic [7:0] c, y, mo, wd, md, h, mi, s);
    rd_chk(req, 4'h0, s);  rd_chk(req, 4'h1, mi); rd_chk(req, 4'h2, h);
    rd_chk(req, 4'h3, md); rd_chk(req, 4'h4, wd); rd_chk(req, 4'h5, mo);
    rd_chk(req, 4'h6, y);  rd_chk(req, 4'h7, c);
  endtask

  task automatic t_reset();
    expect_time("R1 reset time", 8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd_chk("R1 reset alarm", 4'h8, 8'h00);
    rd_chk("R1 reset alarm", 4'hB, 8'h00);
    rd_chk("R1 reset enables", 4'hC, 8'h00);
    rd_chk("R1 reset flags", 4'hD, 8'h00);
    rd_chk("R1 reset control", 4'hE, 8'h01);
    rd_chk("R2 unused address", 4'hF, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_basic();
    set_time(8'h20, 8'h24, 8'h05, 8'h03, 8'h05, 8'h12, 8'h34, 8'h56);
    tick();
    expect_time("R3 step", 8'h20, 8'h24, 8'h05, 8'h03, 8'h05, 8'h12, 8'h34, 8'h57);
  endtask

  task automatic t_rollover();
    set_time(8'h20, 8'h23, 8'h12, 8'h07, 8'h31, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R4 new year", 8'h20, 8'h24, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h20, 8'h24, 8'h02, 8'h03, 8'h28, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R4 leap feb 29", 8'h20, 8'h24, 8'h02, 8'h04, 8'h29, 8'h00, 8'h00, 8'h00);
    tick();
    rd_chk("R4 leap feb sec", 4'h0, 8'h01);
    set_time(8'h20, 8'h24, 8'h02, 8'h04, 8'h29, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R4 leap feb end", 8'h20, 8'h24, 8'h03, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h20, 8'h23, 8'h02, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R4 common feb", 8'h20, 8'h23, 8'h03, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h20, 8'h24, 8'h04, 8'h02, 8'h30, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R4 30-day month", 8'h20, 8'h24, 8'h05, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h20, 8'h99, 8'h12, 8'h05, 8'h31, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R4 century", 8'h21, 8'h00, 8'h01, 8'h06, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h20, 8'h24, 8'h05, 8'h03, 8'h05, 8'h10, 8'h19, 8'h59);
    tick();
    rd_chk("R4 minute carry", 4'h1, 8'h20);
    rd_chk("R4 minute carry", 4'h0, 8'h00);
  endtask

  task automatic t_freeze();
    set_time(8'h20, 8'h24, 8'h05, 8'h03, 8'h05, 8'h10, 8'h10, 8'h10);
    wr(4'hE, 8'h09);
    rd_chk("R2 control freeze", 4'hE, 8'h09);
    tick(); tick(); tick();
    rd_chk("R6 frozen", 4'h0, 8'h10);
    wr(4'hE, 8'h01);
    rd_chk("R6 no commit", 4'h0, 8'h10);
    tick();
    rd_chk("R6 counters ran", 4'h0, 8'h14);
  endtask

  task automatic t_in_progress();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0; wr_en = 1'b1; addr = 4'hE; wdata = 8'h09;
    @(negedge clk); wr_en = 1'b0;
    rd_chk("R7 transfer done", 4'h0, 8'h15);
    tick();
    rd_chk("R7 then frozen", 4'h0, 8'h15);
    wr(4'hE, 8'h01);
    tick();
    rd_chk("R7 resumed", 4'h0, 8'h17);
    // freeze written in the tick cycle itself
    @(negedge clk); sec_tick = 1'b1; wr_en = 1'b1; addr = 4'hE; wdata = 8'h09;
    @(negedge clk); sec_tick = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    rd_chk("R7 freeze at tick", 4'h0, 8'h18);
    wr(4'hE, 8'h01);
  endtask

  task automatic t_ignored();
    wr(4'h0, 8'h33);
    rd_chk("R8 write ignored", 4'h0, 8'h18);
    wr(4'hE, 8'h09);
    wr(4'hE, 8'h01);
    tick();
    rd_chk("R8 counters intact", 4'h0, 8'h19);
  endtask

  task automatic t_commit_tick();
    wr(4'hE, 8'h09);
    wr(4'h0, 8'h40);
    @(negedge clk); wr_en = 1'b1; addr = 4'hE; wdata = 8'h01; sec_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; sec_tick = 1'b0;
    @(negedge clk);
    rd_chk("R9 commit wins", 4'h0, 8'h40);
    rd_chk("R9 other field", 4'h1, 8'h10);
    tick();
    rd_chk("R9 counts on", 4'h0, 8'h41);
  endtask

  task automatic t_run();
    wr(4'hE, 8'h00);
    rd_chk("R5 control", 4'hE, 8'h00);
    tick(); tick();
    rd_chk("R5 stopped", 4'h0, 8'h41);
    wr(4'hE, 8'h01);
    tick();
    rd_chk("R5 restarted", 4'h0, 8'h42);
  endtask

  task automatic t_alarm();
    wr(4'h8, 8'h43); wr(4'h9, 8'h10); wr(4'hA, 8'h10); wr(4'hB, 8'h05);
    wr(4'hC, 8'h01);
    check("R10 irq idle", {7'b0, irq}, 8'h00);
    tick();
    check("R10 irq on match", {7'b0, irq}, 8'h01);
    rd_chk("R11 flag read", 4'hD, 8'h01);
    check("R11 irq after read", {7'b0, irq}, 8'h00);
    rd_chk("R11 flag cleared", 4'hD, 8'h00);
    wr(4'h8, 8'h44); wr(4'hC, 8'h00);
    tick();
    check("R10 irq masked", {7'b0, irq}, 8'h00);
    rd_chk("R10 flag without enable", 4'hD, 8'h01);
    wr(4'h8, 8'h50);
    tick();
    rd_chk("R10 no match", 4'hD, 8'h00);
  endtask

  task automatic t_read_vs_set();
    logic [7:0] d;
    wr(4'h8, 8'h46); wr(4'hC, 8'h01);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0; rd_en = 1'b1; addr = 4'hD;
    #2 d = rdata;
    @(negedge clk); rd_en = 1'b0;
    check("R11 read returns old", d, 8'h00);
    check("R11 set wins irq", {7'b0, irq}, 8'h01);
    rd_chk("R11 set wins flag", 4'hD, 8'h01);
  endtask

  task automatic t_readback();
    rd_chk("R12 alarm sec", 4'h8, 8'h46);
    rd_chk("R12 alarm min", 4'h9, 8'h10);
    rd_chk("R12 alarm hour", 4'hA, 8'h10);
    rd_chk("R12 alarm mday", 4'hB, 8'h05);
    wr(4'hC, 8'hFF);
    rd_chk("R12 enables mask", 4'hC, 8'h03);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_rollover();
    t_freeze();
    t_in_progress();
    t_ignored();
    t_commit_tick();
    t_run();
    t_alarm();
    t_read_vs_set();
    t_readback();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule